// File: doc/BRIEF.md
# Debounced level interrupt controller

This block watches a bank of external signal lines that are only ever inputs. Each line passes through a two-stage synchronizer. Software arms it with a one-shot start pulse. After that, the line must hold its selected active level for a programmed number of millisecond ticks before a sticky status bit is set. The status bits are gated by per-line enables and combined into one registered, active-high interrupt.

Software reaches the block over a plain register bus with an address, a write strobe, write data and combinational read data. Detection works on levels only. To detect an edge, the interrupt handler flips the line's polarity bit and re-arms the line.

The bit-vector registers use one bit per line:

| Offset | Register | Access |
|---|---|---|
| 0x00 | line levels | read only |
| 0x04 | level-read mask | read/write |
| 0x14 | polarity | read/write |
| 0x18 | enable | read/write |
| 0x1C | raw status | read only |
| 0x20 | masked status | read only |
| 0x24 | clear | write-one, reads 0 |
| 0x28 | arm | write-one, reads 0 |

Line n has a debounce register at 0x40 + 4*n.

Top module: `dbl_intc`

## Requirements
- R1: After reset every register reads 0, `irq_o` is low, and no line is armed. With polarity 0 and all lines low (the active level), raw status stays 0 until a line is armed.
- R2: Register 0x00 returns, for each line n, the synchronized level of `lines_i[n]` AND bit n of the mask register (0x04). Writes to 0x00 change nothing.
- R3: The registers at 0x04, 0x14 and 0x18 store bits 15:0 of a write. They read back those bits, and bits 31:16 read 0.
- R4: Polarity bit n = 1 makes high the active level of line n. Polarity bit n = 0 makes low the active level.
- R5: Writing 1 to bit n of 0x28 arms line n. A line that is not armed never sets status. Register 0x28 always reads 0.
- R6: An armed line sets raw status bit n (0x1C) once it has seen the active level continuously across N tick pulses, where N is the debounce value. With N = 0, the bit is set on the first clock where the synchronized level is active.
- R7: While a line is armed, any clock with the inactive level resets its tick count to 0.
- R8: Raw status is set at most once per arm. After it is set, the line is idle, and clearing the bit leaves it at 0 even with the level still active, until the line is armed again.
- R9: Register 0x20 reads raw status AND enable (0x18).
- R10: Writing 1 to bit n of 0x24 clears raw status bit n, and 0 bits have no effect. Register 0x24 reads 0, and writes to 0x1C are ignored.
- R11: Register 0x40 + 4*n holds the 12-bit debounce value of line n in bits 11:0. Bits 31:12 read 0, and each line's value is independent.
- R12: `irq_o` is a register that is high exactly one clock after any bit of raw status AND enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle pulse every millisecond, paces debounce |
| lines_i | input | 16 | Asynchronous external lines |
| addr_i | input | 8 | Register byte address |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Combined interrupt, active high |

## Verification
The properties assume the following about the inputs:
- `tick_i` is a single-cycle pulse synchronous to `clk_i`.
- Bus addresses are word-aligned.
- A line level is held long enough for the two synchronizer stages to pass it before the debounce logic is expected to react.

The stimulus changes every input at the falling clock edge and holds each line level for at least three clocks before it counts ticks or samples status. Tick pulses are issued one at a time, so a count never races a level change.

// File: rtl/dbl_intc_pkg.sv
package dbl_intc_pkg;
  // Register byte offsets; the per-line debounce block begins at OFS_CTRL
  localparam int OFS_DATA = 'h00;
  localparam int OFS_DMSK = 'h04;
  localparam int OFS_POL  = 'h14;
  localparam int OFS_EN   = 'h18;
  localparam int OFS_RAW  = 'h1C;
  localparam int OFS_MIS  = 'h20;
  localparam int OFS_CLR  = 'h24;
  localparam int OFS_TRIG = 'h28;
  localparam int OFS_CTRL = 'h40;

  typedef enum logic {
    CH_IDLE  = 1'b0,
    CH_ARMED = 1'b1
  } ch_state_e;
endpackage

// File: rtl/dbl_sync.sv
module dbl_sync #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/dbl_chan.sv
module dbl_chan
  import dbl_intc_pkg::*;
#(
  parameter int DBW = 12
) (
  input  logic           clk_i,
  input  logic           rst_n,
  input  logic           tick_i,
  input  logic           start_i,
  input  logic           level_i,
  input  logic           pol_i,
  input  logic [DBW-1:0] limit_i,
  output logic           hit_o,
  output logic           armed_o
);
  ch_state_e      st_q, st_d;
  logic [DBW-1:0] cnt_q, cnt_d;
  logic           match;

  assign match = (level_i == pol_i);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    hit_o = 1'b0;
    if (start_i) begin
      st_d  = CH_ARMED;
      cnt_d = '0;
    end else if (st_q == CH_ARMED) begin
      if (!match) begin
        cnt_d = '0;
      end else if (cnt_q >= limit_i) begin
        hit_o = 1'b1;
        st_d  = CH_IDLE;
        cnt_d = '0;
      end else if (tick_i) begin
        cnt_d = cnt_q + DBW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CH_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign armed_o = (st_q == CH_ARMED);
endmodule

// File: rtl/dbl_intc.sv
module dbl_intc
  import dbl_intc_pkg::*;
#(
  parameter int NCH = 16,
  parameter int DBW = 12,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic [NCH-1:0] lines_i,
  input  logic [AW-1:0]  addr_i,
  input  logic           wr_en_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  output logic           irq_o
);
  localparam logic [AW-1:0] A_DATA = AW'(OFS_DATA);
  localparam logic [AW-1:0] A_DMSK = AW'(OFS_DMSK);
  localparam logic [AW-1:0] A_POL  = AW'(OFS_POL);
  localparam logic [AW-1:0] A_EN   = AW'(OFS_EN);
  localparam logic [AW-1:0] A_RAW  = AW'(OFS_RAW);
  localparam logic [AW-1:0] A_MIS  = AW'(OFS_MIS);
  localparam logic [AW-1:0] A_TRIG = AW'(OFS_TRIG);
  localparam logic [AW-1:0] A_CLR  = AW'(OFS_CLR);

  // Reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n      <= rst_meta_q;
    end
  end

  logic [NCH-1:0] lvl;
  dbl_sync #(.W(NCH)) u_sync (
    .clk_i (clk_i),
    .rst_n (rst_n),
    .d_i   (lines_i),
    .q_o   (lvl)
  );

  logic [NCH-1:0] dmask_q, dmask_d, pol_q, pol_d, en_q, en_d, raw_q, raw_d;
  logic [NCH-1:0] clr_v, start_v, hit_v, armed;
  logic [DBW-1:0] lim_q [NCH];
  logic [NCH-1:0] lim_we;
  logic           we_dmsk, we_pol, we_en, we_clr, we_trig;
  logic           irq_d;
  logic           unused_wdata;

  assign unused_wdata = ^wdata_i;

  assign we_dmsk = wr_en_i && (addr_i == A_DMSK);
  assign we_pol  = wr_en_i && (addr_i == A_POL);
  assign we_en   = wr_en_i && (addr_i == A_EN);
  assign we_clr  = wr_en_i && (addr_i == A_CLR);
  assign we_trig = wr_en_i && (addr_i == A_TRIG);

  // Next-state for the bit-vector registers and interrupt
  always_comb begin
    dmask_d = we_dmsk ? wdata_i[NCH-1:0] : dmask_q;
    pol_d   = we_pol  ? wdata_i[NCH-1:0] : pol_q;
    en_d    = we_en   ? wdata_i[NCH-1:0] : en_q;
    clr_v   = we_clr  ? wdata_i[NCH-1:0] : '0;
    start_v = we_trig ? wdata_i[NCH-1:0] : '0;
    raw_d   = (raw_q & ~clr_v) | hit_v;
    irq_d   = |(raw_q & en_q);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      dmask_q <= '0;
      pol_q   <= '0;
      en_q    <= '0;
      raw_q   <= '0;
      irq_o   <= 1'b0;
    end else begin
      if (we_dmsk) dmask_q <= dmask_d;
      if (we_pol)  pol_q   <= pol_d;
      if (we_en)   en_q    <= en_d;
      raw_q <= raw_d;
      irq_o <= irq_d;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [AW-1:0] A_CTL = AW'(OFS_CTRL + 4 * i);
    assign lim_we[i] = wr_en_i && (addr_i == A_CTL);

    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n)         lim_q[i] <= '0;
      else if (lim_we[i]) lim_q[i] <= wdata_i[DBW-1:0];
    end

    dbl_chan #(.DBW(DBW)) u_chan (
      .clk_i   (clk_i),
      .rst_n   (rst_n),
      .tick_i  (tick_i),
      .start_i (start_v[i]),
      .level_i (lvl[i]),
      .pol_i   (pol_q[i]),
      .limit_i (lim_q[i]),
      .hit_o   (hit_v[i]),
      .armed_o (armed[i])
    );
  end

  // Read multiplexer
  always_comb begin
    rdata_o = '0;
    if      (addr_i == A_DATA) rdata_o[NCH-1:0] = lvl & dmask_q;
    else if (addr_i == A_DMSK) rdata_o[NCH-1:0] = dmask_q;
    else if (addr_i == A_POL)  rdata_o[NCH-1:0] = pol_q;
    else if (addr_i == A_EN)   rdata_o[NCH-1:0] = en_q;
    else if (addr_i == A_RAW)  rdata_o[NCH-1:0] = raw_q;
    else if (addr_i == A_MIS)  rdata_o[NCH-1:0] = raw_q & en_q;
    else begin
      for (int i = 0; i < NCH; i++) begin
        if (addr_i == AW'(OFS_CTRL + 4 * i)) rdata_o[DBW-1:0] = lim_q[i];
      end
    end
  end
endmodule

// File: rtl/dbl_intc_chk.sv
module dbl_intc_chk
  import dbl_intc_pkg::*;
#(
  parameter int NCH = 16,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input logic           clk_i,
  input logic           rst_n,
  input logic [AW-1:0]  addr_i,
  input logic [DW-1:0]  rdata_o,
  input logic           irq_o,
  input logic [NCH-1:0] raw_q,
  input logic [NCH-1:0] en_q,
  input logic [NCH-1:0] dmask_q,
  input logic [NCH-1:0] armed
);
  assert_irq_rise_R12: assert property (@(posedge clk_i) disable iff (!rst_n)
    (|(raw_q & en_q)) |=> irq_o);

  assert_irq_fall_R12: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(|(raw_q & en_q)) |=> !irq_o);

  assert_set_needs_arm_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (raw_q & ~$past(raw_q) & ~$past(armed)) == '0);

  assert_arm_reads_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (addr_i == AW'(OFS_TRIG)) |-> (rdata_o == '0));

  assert_clr_reads_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (addr_i == AW'(OFS_CLR)) |-> (rdata_o == '0));

  assert_level_masked_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (addr_i == AW'(OFS_DATA)) |-> ((rdata_o[NCH-1:0] & ~dmask_q) == '0));
endmodule

bind dbl_intc dbl_intc_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
  .clk_i   (clk_i),
  .rst_n   (rst_n),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .raw_q   (raw_q),
  .en_q    (en_q),
  .dmask_q (dmask_q),
  .armed   (armed)
);

// File: tb/sim_dbl_intc.sv
module sim_dbl_intc;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] lines = '0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dbl_intc u0 (
    .clk_i (clk), .rst_ni (rst_n), .tick_i (tick), .lines_i (lines),
    .addr_i (addr), .wr_en_i (wr_en), .wdata_i (wdata),
    .rdata_o (rdata), .irq_o (irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(10);
    // R1: reset state, lines low (active for polarity 0) but nothing armed
    rd(8'h04, v); chk("R1 mask", v, 0);
    rd(8'h14, v); chk("R1 pol", v, 0);
    rd(8'h18, v); chk("R1 en", v, 0);
    rd(8'h1C, v); chk("R1 raw", v, 0);
    rd(8'h40, v); chk("R1 ctrl0", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // Sweep every line under both polarities, zero debounce
    for (int p = 0; p < 2; p++) begin
      wr(8'h14, p ? 32'hFFFF : 32'h0);
      for (int ch = 0; ch < 16; ch++) begin
        lines = p ? 16'h0000 : 16'hFFFF;
        wr(8'h18, (ch % 2 == 1) ? (32'd1 << ch) : 32'd0);
        wr(8'h24, 32'hFFFF);
        wr(8'h28, 32'd1 << ch);
        idle(4);
        rd(8'h1C, v); chk("R5 armed inactive", v, 0);
        lines[ch] = p[0];
        idle(4);
        rd(8'h1C, v); chk("R4 R6 polarity set", v, 32'd1 << ch);
        chk("R12 irq", {31'd0, irq}, (ch % 2 == 1) ? 32'd1 : 32'd0);
        rd(8'h20, v); chk("R9 masked", v, (ch % 2 == 1) ? (32'd1 << ch) : 32'd0);
        wr(8'h24, 32'd1 << ch);
        idle(2);
        rd(8'h1C, v); chk("R10 clear", v, 0);
      end
    end

    // R6 debounce of 3 ticks on line 3, active high
    lines = '0;
    wr(8'h18, 32'h8);
    wr(8'h4C, 32'd3);
    wr(8'h28, 32'h8);
    lines[3] = 1'b1;
    idle(3);
    pulse_tick(); pulse_tick();
    idle(3);
    rd(8'h1C, v); chk("R6 before N ticks", v, 0);
    pulse_tick();
    idle(3);
    rd(8'h1C, v); chk("R6 after N ticks", v, 32'h8);
    chk("R12 irq debounce", {31'd0, irq}, 1);

    // R7 restart on mismatch
    wr(8'h24, 32'h8);
    wr(8'h28, 32'h8);
    idle(3);
    pulse_tick(); pulse_tick();
    lines[3] = 1'b0;
    idle(4);
    lines[3] = 1'b1;
    idle(3);
    pulse_tick(); pulse_tick();
    idle(2);
    rd(8'h1C, v); chk("R7 count restarted", v, 0);
    pulse_tick();
    idle(3);
    rd(8'h1C, v); chk("R7 set after full run", v, 32'h8);

    // R10 zero bits in clear do nothing; raw status not writable
    wr(8'h24, 32'h0);
    rd(8'h1C, v); chk("R10 clear zero", v, 32'h8);
    wr(8'h1C, 32'h0);
    rd(8'h1C, v); chk("R10 raw write ignored", v, 32'h8);
    rd(8'h24, v); chk("R10 clear reads 0", v, 0);

    // R8 once per arm
    wr(8'h4C, 32'd0);
    wr(8'h24, 32'h8);
    idle(5);
    rd(8'h1C, v); chk("R8 no re-set", v, 0);
    chk("R12 irq low", {31'd0, irq}, 0);
    wr(8'h28, 32'h8);
    idle(3);
    rd(8'h1C, v); chk("R8 re-armed", v, 32'h8);
    rd(8'h28, v); chk("R5 arm reads 0", v, 0);
    wr(8'h18, 32'h0);
    idle(2);
    chk("R12 irq disabled", {31'd0, irq}, 0);
    rd(8'h20, v); chk("R9 masked disabled", v, 0);

    // R11 debounce registers
    wr(8'h54, 32'hFFFF_F123);
    rd(8'h54, v); chk("R11 field only", v, 32'h123);
    rd(8'h58, v); chk("R11 neighbour", v, 0);
    wr(8'h7C, 32'h0000_0ABC);
    rd(8'h7C, v); chk("R11 last line", v, 32'hABC);
    rd(8'h54, v); chk("R11 independent", v, 32'h123);

    // R3 read/write widths
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, v); chk("R3 mask width", v, 32'hFFFF);
    wr(8'h18, 32'h5A5A_1234);
    rd(8'h18, v); chk("R3 en width", v, 32'h1234);
    wr(8'h18, 32'h0);

    // R2 level reads through mask
    lines = 16'hA5C3;
    wr(8'h04, 32'h0FF0);
    idle(3);
    rd(8'h00, v); chk("R2 masked level", v, 32'h05C0);
    wr(8'h00, 32'hFFFF);
    rd(8'h00, v); chk("R2 write ignored", v, 32'h05C0);
    wr(8'h04, 32'hFFFF);
    rd(8'h00, v); chk("R2 full mask", v, 32'hA5C3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule